// File: doc/BRIEF.md
# PLL Power and Lock Sequencer

This block is the control state machine that sits next to an analog PLL and a glitch-free clock multiplexer. It owns the PLL power-down control and the multiplexer select, which picks either the bypass clock or the PLL clock. It also owns the divider codes that are presented to the PLL. Software-side logic raises one of three single-cycle requests: power up, power down, or reprogram with new feedback-divider, input-divider and charge-pump codes. The sequencer then carries the request out in a safe order. The clock is moved off the PLL before the PLL loses power. The codes change only while the PLL is powered down. The clock is moved onto the PLL only after it reports lock.

A power-up waits for the lock input against a bounded window, counted in clock cycles by a parameter. If the window runs out, the request ends with a timeout pulse and the multiplexer stays on bypass. A reprogram request is wrapped in a full power-down, code load and power-up. A reprogram that names a zero target rate or a zero reference rate is refused and changes nothing. While a request is in progress the block holds a busy flag. Each request ends with exactly one single-cycle result pulse.

Top module: `pll_pwr_seq`

## Requirements
- R1: After reset, `pll_pdn` is 1, `sel_pll` is 0, `busy`, `done`, `err_timeout` and `err_arg` are 0, and the three code outputs are 0.
- R2: A power-up request accepted on clock edge k while `pll_pdn` is 1 raises `busy` after edge k and clears `pll_pdn` on edge k+1. From edge k+2 onward, `lock_in` is sampled on every edge.
- R3: A power-up request while `pll_pdn` is 0 pulses `done` for one cycle after the accepting edge, leaves `busy` at 0 and changes no other output.
- R4: If `lock_in` is low on LOCK_TIMEOUT consecutive sampling edges, `err_timeout` pulses on the last of them, `sel_pll` stays 0 and `pll_pdn` stays 0. A lock seen on that last edge counts as success.
- R5: When lock is seen, `done` pulses, and on that same edge `sel_pll` goes to 1, but only when HAS_SWITCH is 1. With HAS_SWITCH at 0, `sel_pll` is always 0.
- R6: A power-down request while powered clears `sel_pll` on the edge after acceptance and sets `pll_pdn` one edge later, together with `done`. `sel_pll` is never 1 while `pll_pdn` is 1.
- R7: A power-down request while `pll_pdn` is already 1 pulses `done` and leaves `pll_pdn` and `sel_pll` unchanged.
- R8: A reprogram request runs the power-down sequence (skipped if already down), loads the new codes on the next edge while `pll_pdn` is 1, and then runs the power-up sequence. The code outputs never change while `pll_pdn` is 0.
- R9: A reprogram request with `tgt_rate` or `ref_rate` equal to zero pulses `err_arg` and changes no other output.
- R10: `st_enabled` equals the inverse of `pll_pdn`. `st_locked` is 1 only when `lock_in` is 1 and `pll_pdn` is 0.
- R11: Requests are accepted only while `busy` is 0. Requests raised while busy are ignored. `busy` falls on the same edge as `done` or `err_timeout`. At most one result pulse is high in any cycle.
- R12: Requests raised in the same cycle follow a fixed priority: reprogram first, then power-down, then power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_en | input | 1 | Power-up request, single cycle |
| req_dis | input | 1 | Power-down request, single cycle |
| req_prog | input | 1 | Reprogram request, single cycle |
| new_ndiv | input | NDIV_W | Feedback-divider code for reprogram |
| new_idiv | input | IDIV_W | Input-divider code for reprogram |
| new_cp | input | CP_W | Charge-pump code for reprogram |
| tgt_rate | input | RATE_W | Target rate of the reprogram; zero is refused |
| ref_rate | input | RATE_W | Reference rate of the reprogram; zero is refused |
| lock_in | input | 1 | Lock indication from the PLL |
| pll_pdn | output | 1 | PLL power-down control, 1 = off |
| sel_pll | output | 1 | Multiplexer select, 1 = PLL clock, 0 = bypass |
| pll_ndiv | output | NDIV_W | Feedback-divider code to the PLL |
| pll_idiv | output | IDIV_W | Input-divider code to the PLL |
| pll_cp | output | CP_W | Charge-pump code to the PLL |
| st_enabled | output | 1 | PLL powered |
| st_locked | output | 1 | PLL powered and locked |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished, single cycle |
| err_timeout | output | 1 | Lock wait expired, single cycle |
| err_arg | output | 1 | Reprogram refused for a zero rate, single cycle |

## Verification
Two events can fall on the same edge: the lock input rising and the final edge of the lock window. The bench holds lock low under direct control and raises it just before the last sampling edge. In that case the power-up must end in `done` with the select on the PLL. A second run raises lock one edge later, and that run must end in `err_timeout` with the select on bypass. Both outcomes are judged every cycle against a behavioural queue model of pending steps. Colliding requests, and requests raised while busy, are provoked in the same way and judged against the same model.

// File: rtl/pll_seq_pkg.sv
// Shared types for the PLL power and lock sequencer.
// Assumes: nothing beyond the standard language.
package pll_seq_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SW_OFF,
        ST_PWR_DN,
        ST_LOAD,
        ST_PWR_UP,
        ST_WAIT_LK
    } seq_state_t;

    // Decoded request after priority and argument check
    typedef enum logic [2:0] {
        RQ_NONE,
        RQ_EN,
        RQ_DIS,
        RQ_PROG,
        RQ_REJ
    } req_kind_t;

endpackage

// File: rtl/pll_req_arb.sv
// Request priority selector.
// Picks one request per cycle: reprogram over power-down over power-up.
// A reprogram that names a zero rate is turned into a reject.
// Assumes: requests are single-cycle pulses; the caller ignores the result when not idle.
module pll_req_arb
    import pll_seq_pkg::*;
#(
    parameter int RATE_W = 32
) (
    input  logic              req_en,
    input  logic              req_dis,
    input  logic              req_prog,
    input  logic [RATE_W-1:0] tgt_rate,
    input  logic [RATE_W-1:0] ref_rate,
    output req_kind_t         kind
);

    logic rates_ok;

    // A reprogram is valid only with both rates non-zero
    assign rates_ok = (|tgt_rate) && (|ref_rate);

    // Fixed priority decode
    always_comb begin
        if (req_prog)     kind = rates_ok ? RQ_PROG : RQ_REJ;
        else if (req_dis) kind = RQ_DIS;
        else if (req_en)  kind = RQ_EN;
        else              kind = RQ_NONE;
    end

endmodule

// File: rtl/pll_lock_timer.sv
// Lock-wait window counter.
// Counts the sampling edges of a lock wait and flags the last one.
// Assumes: TIMEOUT >= 2; clr comes one cycle before run begins.
module pll_lock_timer #(
    parameter int TIMEOUT = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic last
);

    localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;

    // Final sampling edge of the window
    assign last = (cnt == LAST_VAL);

    // Edge counter, restarted before each wait
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (run && !last) cnt <= cnt + 1'b1;
    end

    AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_VAL);                                           // R4

endmodule

// File: rtl/pll_code_reg.sv
// Divider and charge-pump code holder.
// Captures the codes of an accepted reprogram and presents them to the
// PLL only when told to apply them.
// Assumes: apply is raised only while the PLL is powered down.
module pll_code_reg #(
    parameter int NDIV_W = 8,
    parameter int IDIV_W = 3,
    parameter int CP_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              apply,
    input  logic [NDIV_W-1:0] in_ndiv,
    input  logic [IDIV_W-1:0] in_idiv,
    input  logic [CP_W-1:0]   in_cp,
    output logic [NDIV_W-1:0] out_ndiv,
    output logic [IDIV_W-1:0] out_idiv,
    output logic [CP_W-1:0]   out_cp
);

    localparam int TOT_W = NDIV_W + IDIV_W + CP_W;

    logic [TOT_W-1:0] pend;
    logic [TOT_W-1:0] live;

    // Hold the codes of the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= '0;
        else if (cap) pend <= {in_ndiv, in_idiv, in_cp};
    end

    // Copy the held codes to the PLL side
    always_ff @(posedge clk) begin
        if (!rst_n)     live <= '0;
        else if (apply) live <= pend;
    end

    assign {out_ndiv, out_idiv, out_cp} = live;

endmodule

// File: rtl/pll_seq_ctrl.sv
// Sequencer state machine.
// Orders the multiplexer select, the power-down control, the code load
// and the lock wait for all three request kinds, and issues result pulses.
// Assumes: kind is already prioritised; the timer flags its last edge.
module pll_seq_ctrl
    import pll_seq_pkg::*;
#(
    parameter bit HAS_SWITCH = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  req_kind_t kind,
    input  logic      lock_in,
    input  logic      tmr_last,
    output logic      pll_pdn,
    output logic      sel_pll,
    output logic      busy,
    output logic      done,
    output logic      err_to,
    output logic      err_arg,
    output logic      tmr_clr,
    output logic      tmr_run,
    output logic      code_cap,
    output logic      code_apply
);

    seq_state_t state;
    logic       prog_on;

    // Control strobes toward the timer and the code holder
    assign busy       = (state != ST_IDLE);
    assign tmr_clr    = (state == ST_PWR_UP);
    assign tmr_run    = (state == ST_WAIT_LK);
    assign code_cap   = (state == ST_IDLE) && (kind == RQ_PROG);
    assign code_apply = (state == ST_LOAD);

    // Phase sequencing and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            prog_on <= 1'b0;
            pll_pdn <= 1'b1;
            sel_pll <= 1'b0;
            done    <= 1'b0;
            err_to  <= 1'b0;
            err_arg <= 1'b0;
        end else begin
            done    <= 1'b0;
            err_to  <= 1'b0;
            err_arg <= 1'b0;
            case (state)
                ST_IDLE: begin
                    case (kind)
                        RQ_REJ:  err_arg <= 1'b1;
                        RQ_PROG: begin
                            prog_on <= 1'b1;
                            state   <= pll_pdn ? ST_LOAD : ST_SW_OFF;
                        end
                        RQ_DIS: begin
                            prog_on <= 1'b0;
                            if (pll_pdn) done <= 1'b1;
                            else         state <= ST_SW_OFF;
                        end
                        RQ_EN: begin
                            if (!pll_pdn) done <= 1'b1;
                            else          state <= ST_PWR_UP;
                        end
                        default: ;
                    endcase
                end
                ST_SW_OFF: begin
                    if (HAS_SWITCH) sel_pll <= 1'b0;
                    state <= ST_PWR_DN;
                end
                ST_PWR_DN: begin
                    pll_pdn <= 1'b1;
                    if (prog_on) begin
                        state <= ST_LOAD;
                    end else begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_LOAD: state <= ST_PWR_UP;
                ST_PWR_UP: begin
                    pll_pdn <= 1'b0;
                    state   <= ST_WAIT_LK;
                end
                ST_WAIT_LK: begin
                    if (lock_in) begin
                        if (HAS_SWITCH) sel_pll <= 1'b1;
                        done    <= 1'b1;
                        prog_on <= 1'b0;
                        state   <= ST_IDLE;
                    end else if (tmr_last) begin
                        err_to  <= 1'b1;
                        prog_on <= 1'b0;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_SEL_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        sel_pll |-> !pll_pdn);                                      // R6
    AST_PDN_RISE_ON_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_pdn) |-> !$past(sel_pll));                        // R6
    AST_SEL_RISE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_pll) |-> $past(lock_in) && done);                 // R5
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_to, err_arg}));                         // R11
    AST_BUSY_ENDS_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || err_to));                          // R11
    AST_TIMEOUT_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        err_to |-> !$past(lock_in) && !sel_pll);                    // R4

endmodule

// File: rtl/pll_pwr_seq.sv
// PLL power and lock sequencer, top level.
// Joins the request selector, the state machine, the lock-wait timer and
// the code holder, and derives the enabled and locked status.
// Assumes: the PLL model and clock multiplexer sit outside; requests are pulses.
module pll_pwr_seq
    import pll_seq_pkg::*;
#(
    parameter int NDIV_W       = 8,
    parameter int IDIV_W       = 3,
    parameter int CP_W         = 5,
    parameter int RATE_W       = 32,
    parameter int LOCK_TIMEOUT = 1250000,
    parameter bit HAS_SWITCH   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_en,
    input  logic              req_dis,
    input  logic              req_prog,
    input  logic [NDIV_W-1:0] new_ndiv,
    input  logic [IDIV_W-1:0] new_idiv,
    input  logic [CP_W-1:0]   new_cp,
    input  logic [RATE_W-1:0] tgt_rate,
    input  logic [RATE_W-1:0] ref_rate,
    input  logic              lock_in,
    output logic              pll_pdn,
    output logic              sel_pll,
    output logic [NDIV_W-1:0] pll_ndiv,
    output logic [IDIV_W-1:0] pll_idiv,
    output logic [CP_W-1:0]   pll_cp,
    output logic              st_enabled,
    output logic              st_locked,
    output logic              busy,
    output logic              done,
    output logic              err_timeout,
    output logic              err_arg
);

    req_kind_t kind;
    logic      tmr_clr;
    logic      tmr_run;
    logic      tmr_last;
    logic      code_cap;
    logic      code_apply;

    pll_req_arb #(.RATE_W(RATE_W)) u_arb (
        .req_en   (req_en),
        .req_dis  (req_dis),
        .req_prog (req_prog),
        .tgt_rate (tgt_rate),
        .ref_rate (ref_rate),
        .kind     (kind)
    );

    pll_seq_ctrl #(.HAS_SWITCH(HAS_SWITCH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .lock_in    (lock_in),
        .tmr_last   (tmr_last),
        .pll_pdn    (pll_pdn),
        .sel_pll    (sel_pll),
        .busy       (busy),
        .done       (done),
        .err_to     (err_timeout),
        .err_arg    (err_arg),
        .tmr_clr    (tmr_clr),
        .tmr_run    (tmr_run),
        .code_cap   (code_cap),
        .code_apply (code_apply)
    );

    pll_lock_timer #(.TIMEOUT(LOCK_TIMEOUT)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .run   (tmr_run),
        .last  (tmr_last)
    );

    pll_code_reg #(.NDIV_W(NDIV_W), .IDIV_W(IDIV_W), .CP_W(CP_W)) u_codes (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (code_cap),
        .apply    (code_apply),
        .in_ndiv  (new_ndiv),
        .in_idiv  (new_idiv),
        .in_cp    (new_cp),
        .out_ndiv (pll_ndiv),
        .out_idiv (pll_idiv),
        .out_cp   (pll_cp)
    );

    // Status derived from the power control and the lock input
    assign st_enabled = !pll_pdn;
    assign st_locked  = lock_in && !pll_pdn;

    AST_CODES_HELD_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_pdn && $past(!pll_pdn)) |-> $stable({pll_ndiv, pll_idiv, pll_cp})); // R8
    AST_REJECT_KEEPS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        err_arg |-> $stable(pll_pdn) && $stable(sel_pll));          // R9

endmodule

// File: tb/pll_pwr_seq_bench.sv
module pll_pwr_seq_bench;

    localparam int TO = 20;
    localparam int OP_SWOFF = 0, OP_PDN = 1, OP_LOAD = 2, OP_PUP = 3, OP_WAIT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_en = 1'b0, req_dis = 1'b0, req_prog = 1'b0;
    logic [7:0] new_ndiv = '0;
    logic [2:0] new_idiv = '0;
    logic [4:0] new_cp = '0;
    logic [31:0] tgt_rate = '0, ref_rate = '0;
    logic       lock_in = 1'b0;
    logic       pll_pdn, sel_pll, st_enabled, st_locked, busy, done, err_timeout, err_arg;
    logic [7:0] pll_ndiv;
    logic [2:0] pll_idiv;
    logic [4:0] pll_cp;
    logic       n_pdn, n_sel, n_en, n_lk, n_busy, n_done, n_to, n_arg;
    logic [7:0] n_ndiv;
    logic [2:0] n_idiv;
    logic [4:0] n_cp;

    int n_cmp = 0, n_bad = 0, cyc = 0;

    always #4 clk = ~clk;

    pll_pwr_seq #(.LOCK_TIMEOUT(TO), .HAS_SWITCH(1'b1)) u_pll_pwr_seq (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_dis(req_dis), .req_prog(req_prog),
        .new_ndiv(new_ndiv), .new_idiv(new_idiv), .new_cp(new_cp),
        .tgt_rate(tgt_rate), .ref_rate(ref_rate), .lock_in(lock_in),
        .pll_pdn(pll_pdn), .sel_pll(sel_pll), .pll_ndiv(pll_ndiv), .pll_idiv(pll_idiv),
        .pll_cp(pll_cp), .st_enabled(st_enabled), .st_locked(st_locked), .busy(busy),
        .done(done), .err_timeout(err_timeout), .err_arg(err_arg)
    );

    pll_pwr_seq #(.LOCK_TIMEOUT(TO), .HAS_SWITCH(1'b0)) u_pll_pwr_seq_nosw (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_dis(req_dis), .req_prog(req_prog),
        .new_ndiv(new_ndiv), .new_idiv(new_idiv), .new_cp(new_cp),
        .tgt_rate(tgt_rate), .ref_rate(ref_rate), .lock_in(lock_in),
        .pll_pdn(n_pdn), .sel_pll(n_sel), .pll_ndiv(n_ndiv), .pll_idiv(n_idiv),
        .pll_cp(n_cp), .st_enabled(n_en), .st_locked(n_lk), .busy(n_busy),
        .done(n_done), .err_timeout(n_to), .err_arg(n_arg)
    );

    // PLL model: lock after a delay once powered, or forced by the bench
    int   lk_dly = 5, lk_cnt = 0;
    bit   lk_forced = 0, lk_val = 0;
    always @(negedge clk) begin
        if (pll_pdn) lk_cnt = 0;
        else if (lk_cnt < 1000) lk_cnt++;
        lock_in <= lk_forced ? lk_val : (!pll_pdn && lk_cnt >= lk_dly);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Reference model: a queue of pending steps
    int   ops[$];
    bit   m_pdn = 1, m_sel = 0, m_done = 0, m_to = 0, m_arg = 0;
    logic [15:0] m_codes = '0, m_pend = '0;
    int   m_wcnt = 0;
    bit   seen_done = 0, seen_to = 0, seen_arg = 0;

    always begin
        @(posedge clk);
        cyc++;
        m_done = 0; m_to = 0; m_arg = 0;
        if (!rst_n) begin
            ops.delete(); m_pdn = 1; m_sel = 0; m_codes = '0; m_pend = '0;
        end else if (ops.size() == 0) begin
            if (req_prog) begin
                if (tgt_rate == 0 || ref_rate == 0) m_arg = 1;
                else begin
                    m_pend = {new_ndiv, new_idiv, new_cp};
                    if (!m_pdn) begin ops.push_back(OP_SWOFF); ops.push_back(OP_PDN); end
                    ops.push_back(OP_LOAD); ops.push_back(OP_PUP); ops.push_back(OP_WAIT);
                end
            end else if (req_dis) begin
                if (m_pdn) m_done = 1;
                else begin ops.push_back(OP_SWOFF); ops.push_back(OP_PDN); end
            end else if (req_en) begin
                if (!m_pdn) m_done = 1;
                else begin ops.push_back(OP_PUP); ops.push_back(OP_WAIT); end
            end
        end else begin
            case (ops[0])
                OP_SWOFF: begin m_sel = 0; void'(ops.pop_front()); end
                OP_PDN: begin
                    m_pdn = 1; void'(ops.pop_front());
                    if (ops.size() == 0) m_done = 1;
                end
                OP_LOAD: begin m_codes = m_pend; void'(ops.pop_front()); end
                OP_PUP: begin m_pdn = 0; m_wcnt = 0; void'(ops.pop_front()); end
                default: begin
                    if (lock_in) begin
                        m_sel = 1; m_done = 1; void'(ops.pop_front());
                    end else if (m_wcnt == TO - 1) begin
                        m_to = 1; void'(ops.pop_front());
                    end else m_wcnt++;
                end
            endcase
        end
        #2;
        chk("R6 pdn", pll_pdn, m_pdn);
        chk("R5 sel", sel_pll, m_sel);
        chk("R8 codes", {pll_ndiv, pll_idiv, pll_cp}, m_codes);
        chk("R3 done", done, m_done);
        chk("R4 timeout", err_timeout, m_to);
        chk("R9 err_arg", err_arg, m_arg);
        chk("R11 busy", busy, ops.size() != 0);
        chk("R10 enabled", st_enabled, !m_pdn);
        chk("R10 locked", st_locked, lock_in && !m_pdn);
        chk("R5 nosw sel", n_sel, 0);
        chk("R5 nosw pdn", n_pdn, m_pdn);
        if (done) seen_done = 1;
        if (err_timeout) seen_to = 1;
        if (err_arg) seen_arg = 1;
        if (cyc > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic clr_seen();
        seen_done = 0; seen_to = 0; seen_arg = 0;
    endtask

    task automatic pulse(input bit e, input bit d, input bit p);
        @(negedge clk);
        req_en = e; req_dis = d; req_prog = p;
        @(negedge clk);
        req_en = 0; req_dis = 0; req_prog = 0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pdn", pll_pdn, 1); chk("R1 sel", sel_pll, 0);
        chk("R1 busy", busy, 0); chk("R1 codes", {pll_ndiv, pll_idiv, pll_cp}, 0);

        // R2 power-up from off
        clr_seen(); pulse(1, 0, 0);
        chk("R2 on", pll_pdn, 0); chk("R2 sel", sel_pll, 1); chk("R2 done", seen_done, 1);

        // R3 power-up while on
        clr_seen(); pulse(1, 0, 0);
        chk("R3 done", seen_done, 1); chk("R3 sel", sel_pll, 1);

        // R6 power-down
        clr_seen(); pulse(0, 1, 0);
        chk("R6 off", pll_pdn, 1); chk("R6 sel", sel_pll, 0);

        // R7 power-down while off
        clr_seen(); pulse(0, 1, 0);
        chk("R7 done", seen_done, 1); chk("R7 pdn", pll_pdn, 1);

        // R8 reprogram from off, then from on
        new_ndiv = 8'h5a; new_idiv = 3'd3; new_cp = 5'd17; tgt_rate = 100; ref_rate = 25;
        clr_seen(); pulse(0, 0, 1);
        chk("R8 ndiv", pll_ndiv, 8'h5a); chk("R8 on", pll_pdn, 0);
        new_ndiv = 8'hc3; new_idiv = 3'd7; new_cp = 5'd9;
        lk_dly = 9;
        clr_seen(); pulse(0, 0, 1);
        chk("R8 codes", {pll_ndiv, pll_idiv, pll_cp}, {8'hc3, 3'd7, 5'd9});

        // R9 zero rates refused
        new_ndiv = 8'h11; tgt_rate = 0;
        clr_seen(); pulse(0, 0, 1);
        chk("R9 arg", seen_arg, 1); chk("R9 ndiv", pll_ndiv, 8'hc3);
        tgt_rate = 5; ref_rate = 0;
        clr_seen(); pulse(0, 0, 1);
        chk("R9 arg ref", seen_arg, 1); chk("R9 pdn", pll_pdn, 0);
        ref_rate = 25;

        // R12 priority: power-down beats power-up; reject beats power-down
        clr_seen(); pulse(1, 1, 0);
        chk("R12 dis wins", pll_pdn, 1);
        tgt_rate = 0;
        clr_seen(); pulse(0, 1, 1);
        chk("R12 prog wins", seen_arg, 1);
        tgt_rate = 5;

        // R11 request while busy is ignored
        lk_dly = 12;
        @(negedge clk); req_en = 1; @(negedge clk); req_en = 0;
        repeat (4) @(negedge clk);
        req_dis = 1; @(negedge clk); req_dis = 0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R11 ignored", pll_pdn, 0);
        pulse(0, 1, 0);

        // R4 timeout with lock held low
        lk_forced = 1; lk_val = 0;
        clr_seen(); pulse(1, 0, 0);
        chk("R4 to", seen_to, 1); chk("R4 sel", sel_pll, 0); chk("R4 pdn", pll_pdn, 0);
        chk("R10 locked off", st_locked, 0);
        pulse(0, 1, 0);
        lk_val = 1; @(negedge clk);
        chk("R10 lock while off", st_locked, 0);
        lk_val = 0;

        // R4 lock on the final window edge wins
        clr_seen();
        @(negedge clk); req_en = 1; @(negedge clk); req_en = 0;
        @(negedge clk);
        repeat (TO - 1) @(negedge clk);
        lk_val = 1;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R4 last edge lock", seen_to, 0); chk("R4 last edge sel", sel_pll, 1);
        lk_val = 0; pulse(0, 1, 0);

        // R4 lock one edge late times out
        clr_seen();
        @(negedge clk); req_en = 1; @(negedge clk); req_en = 0;
        @(negedge clk);
        repeat (TO) @(negedge clk);
        lk_val = 1;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R4 late lock", seen_to, 1); chk("R4 late sel", sel_pll, 0);
        lk_forced = 0;
        pulse(0, 1, 0);

        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule